// File: doc/BRIEF.md
# Pending-Table Synchronizer

When message-signalled interrupts are switched on for a redistributor, this block copies the pending state of every active interrupt ID from a bitmap in memory into a local pending array. A start strobe begins a scan. IDs then arrive one per handshake on a valid/ready stream, and a marker flags the final ID. For each ID the block finds the byte and bit in the bitmap that belong to it. It fetches that byte through a single-outstanding byte read port and writes the selected bit into the pending array.

The block keeps the byte it fetched most recently, along with that byte's offset. When the next ID falls in the same byte, the block uses the kept copy and issues no read. A scan stops as soon as a read returns an error. The whole scan is skipped when the table-zeroed flag is set at start. The pending array can be read combinationally through a lookup port.

Top module: `pend_table_sync`

## Requirements
- R1: For an ID, the read address is the table base plus ID shifted right by 3 (integer divide by 8). The loaded bit is bit (ID mod 8) of the returned byte, with bit 0 the least significant. The address is held steady until the read is acknowledged.
- R2: The table base is bits 47:16 of `pendbase_i`, placed at address bits 47:16, with address bits 15:0 zero. Bits 63:48 and 15:0 of `pendbase_i` have no effect. The base is captured when the scan starts.
- R3: An ID whose byte offset matches the most recently fetched offset of the current scan issues no read. Its bit is taken from the kept byte, and the block is ready for the next ID on the following cycle.
- R4: The kept offset is invalid at the start of every scan, so the first ID of a scan always causes a read, even if its offset matches the last read of an earlier scan.
- R5: Each accepted ID's pending bit is set to the selected bitmap bit, either 1 or 0. IDs that are not in the list keep their pending value.
- R6: A read acknowledged with `mem_err_i` high ends the scan. `err_o` pulses for one cycle in the cycle after the acknowledge, and `busy_o` is low in that same cycle. No `done_o` pulse is given, the ID being fetched keeps its old pending value, and no further ID is accepted.
- R7: If `table_zero_i` is high when a start is seen in idle, no scan takes place. `busy_o` stays low, no read is issued and no ID is accepted. `done_o` pulses one cycle later.
- R8: `busy_o` is high from the cycle after an accepted start until the scan ends. `done_o` pulses for exactly one cycle, in the first cycle after the last ID's bit is written, and `busy_o` is low in that cycle. If the last ID hits the kept byte, this is the cycle after its handshake.
- R9: `id_ready_o` is high only while a scan waits for an ID. A start pulse during a scan is ignored.
- R10: After reset the block is idle, all outputs are low, and every pending bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled in idle |
| table_zero_i | input | 1 | Bitmap known to be all zero; skip scan |
| pendbase_i | input | 64 | Pending base register value (bits 47:16 used) |
| id_valid_i | input | 1 | ID stream valid |
| id_i | input | 10 | Interrupt ID |
| id_last_i | input | 1 | Marks the final ID of the list |
| id_ready_o | output | 1 | ID stream ready |
| mem_req_o | output | 1 | Byte read request, held until acknowledged |
| mem_addr_o | output | 48 | Byte read address |
| mem_ack_i | input | 1 | Read acknowledge carrying data or error |
| mem_data_i | input | 8 | Read data byte |
| mem_err_i | input | 1 | Read failed (valid with `mem_ack_i`) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan completion or skip |
| err_o | output | 1 | One-cycle pulse when a read error aborts the scan |
| rd_id_i | input | 10 | Pending array lookup index |
| rd_pend_o | output | 1 | Pending bit of `rd_id_i` |

## Verification
Most faults in this block appear at the ports within a cycle or two. A stale or wrongly compared kept offset shows up as an extra or missing read on the memory port: read addresses are checked one by one against a queue of expected fetches, and a wrong address is caught at the acknowledge where it occurs. A wrong bit select or a write to the wrong ID is hidden until the pending array is read. For that reason, every scan ends with a sweep of the array against a shadow model, which also catches writes to IDs that were never listed. State-machine faults in the skip, error and end-of-list paths change `busy_o`, `done_o`, `err_o` or `id_ready_o` in the cycle right after the event, and these are sampled at exactly that cycle.

// File: rtl/psync_pkg.sv
package psync_pkg;

  localparam int PS_ID_W     = 10;
  localparam int PS_OFF_W    = PS_ID_W - 3;
  localparam int PS_NUM_IDS  = 1 << PS_ID_W;
  localparam int PS_ADDR_W   = 48;
  localparam int PS_BASE_LSB = 16;

  typedef logic [PS_ID_W-1:0]   id_t;
  typedef logic [PS_OFF_W-1:0]  off_t;
  typedef logic [PS_ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2
  } sync_state_e;

  // byte of the bitmap holding an ID
  function automatic off_t byte_of(input id_t id);
    return id[PS_ID_W-1:3];
  endfunction

  // bit inside that byte
  function automatic logic [2:0] bit_of(input id_t id);
    return id[2:0];
  endfunction

  // aligned table base taken from the base register
  function automatic addr_t table_base(input logic [63:0] reg_val);
    return {reg_val[PS_ADDR_W-1:PS_BASE_LSB], {PS_BASE_LSB{1'b0}}};
  endfunction

  // byte address of an offset inside the table
  function automatic addr_t byte_addr(input addr_t base, input off_t off);
    return base + addr_t'(off);
  endfunction

endpackage

// File: rtl/psync_cache.sv
module psync_cache
  import psync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       fill_i,
  input  off_t       fill_off_i,
  input  logic [7:0] fill_byte_i,
  input  off_t       look_off_i,
  output logic       hit_o,
  output logic [7:0] byte_o
);

  logic       valid_q;
  off_t       off_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      off_q   <= '0;
      byte_q  <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      off_q   <= fill_off_i;
      byte_q  <= fill_byte_i;
    end
  end

  assign hit_o  = valid_q && (off_q == look_off_i);
  assign byte_o = byte_q;

  // a scan start and a fill never coincide
  assert_clear_fill_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear_i && fill_i));

endmodule

// File: rtl/psync_bits.sv
module psync_bits
  import psync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  id_t  wr_id_i,
  input  logic wr_val_i,
  input  id_t  rd_id_i,
  output logic rd_val_o
);

  logic [PS_NUM_IDS-1:0] pend_q;

  for (genvar g = 0; g < PS_NUM_IDS; g++) begin : g_bit
    logic sel;
    assign sel = wr_en_i && (wr_id_i == id_t'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q[g] <= 1'b0;
      else if (sel) pend_q[g] <= wr_val_i;
    end
  end

  assign rd_val_o = pend_q[rd_id_i];

  // nothing in the array moves without a write
  assert_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(pend_q));

endmodule

// File: rtl/psync_ctrl.sv
module psync_ctrl
  import psync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        table_zero_i,
  input  logic [63:0] pendbase_i,
  input  logic        id_valid_i,
  input  id_t         id_i,
  input  logic        id_last_i,
  output logic        id_ready_o,
  output logic        mem_req_o,
  output addr_t       mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [7:0]  mem_data_i,
  input  logic        mem_err_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        cache_clear_o,
  output off_t        look_off_o,
  input  logic        hit_i,
  input  logic [7:0]  cached_byte_i,
  output logic        fill_o,
  output off_t        fill_off_o,
  output logic [7:0]  fill_byte_o,
  output logic        wr_en_o,
  output id_t         wr_id_o,
  output logic        wr_val_o
);

  sync_state_e state_q;
  id_t         id_q;
  logic        last_q;
  addr_t       base_q;

  // named internal events
  logic start_go, start_skip, take, take_hit, take_miss;
  logic resp_ok, resp_bad, finish;

  assign start_go   = (state_q == ST_IDLE) && start_i && !table_zero_i;
  assign start_skip = (state_q == ST_IDLE) && start_i &&  table_zero_i;
  assign id_ready_o = (state_q == ST_WAIT);
  assign take       = id_valid_i && id_ready_o;
  assign take_hit   = take && hit_i;
  assign take_miss  = take && !hit_i;
  assign resp_ok    = (state_q == ST_FETCH) && mem_ack_i && !mem_err_i;
  assign resp_bad   = (state_q == ST_FETCH) && mem_ack_i &&  mem_err_i;
  assign finish     = (take_hit && id_last_i) || (resp_ok && last_q);

  assign look_off_o    = byte_of(id_i);
  assign cache_clear_o = start_go;
  assign fill_o        = resp_ok;
  assign fill_off_o    = byte_of(id_q);
  assign fill_byte_o   = mem_data_i;

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = byte_addr(base_q, byte_of(id_q));

  assign wr_en_o  = take_hit || resp_ok;
  assign wr_id_o  = take_hit ? id_i : id_q;
  assign wr_val_o = take_hit ? cached_byte_i[bit_of(id_i)] : mem_data_i[bit_of(id_q)];

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      last_q  <= 1'b0;
      base_q  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= finish || start_skip;
      err_o  <= resp_bad;
      unique case (state_q)
        ST_IDLE: begin
          if (start_go) begin
            base_q  <= table_base(pendbase_i);
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (take_miss) begin
            id_q    <= id_i;
            last_q  <= id_last_i;
            state_q <= ST_FETCH;
          end else if (take_hit && id_last_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_FETCH: begin
          if (resp_bad)                state_q <= ST_IDLE;
          else if (resp_ok && last_q)  state_q <= ST_IDLE;
          else if (resp_ok)            state_q <= ST_WAIT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_base_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[PS_BASE_LSB-1:PS_OFF_W] == '0));

  assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_hit |=> !mem_req_o);

  assert_miss_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_miss |=> mem_req_o);

  assert_cold_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cache_clear_o |=> !hit_i);

  assert_err_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !done_o && !id_ready_o));

  assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_skip |=> (!busy_o && !mem_req_o));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || err_o));

  assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_ready_o |-> busy_o);

endmodule

// File: rtl/pend_table_sync.sv
module pend_table_sync
  import psync_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 table_zero_i,
  input  logic [63:0]          pendbase_i,
  input  logic                 id_valid_i,
  input  logic [PS_ID_W-1:0]   id_i,
  input  logic                 id_last_i,
  output logic                 id_ready_o,
  output logic                 mem_req_o,
  output logic [PS_ADDR_W-1:0] mem_addr_o,
  input  logic                 mem_ack_i,
  input  logic [7:0]           mem_data_i,
  input  logic                 mem_err_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  input  logic [PS_ID_W-1:0]   rd_id_i,
  output logic                 rd_pend_o
);

  logic       cache_clear, hit, fill, wr_en, wr_val;
  logic [7:0] cached_byte, fill_byte;
  off_t       look_off, fill_off;
  id_t        wr_id;

  psync_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .table_zero_i  (table_zero_i),
    .pendbase_i    (pendbase_i),
    .id_valid_i    (id_valid_i),
    .id_i          (id_i),
    .id_last_i     (id_last_i),
    .id_ready_o    (id_ready_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ack_i     (mem_ack_i),
    .mem_data_i    (mem_data_i),
    .mem_err_i     (mem_err_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .cache_clear_o (cache_clear),
    .look_off_o    (look_off),
    .hit_i         (hit),
    .cached_byte_i (cached_byte),
    .fill_o        (fill),
    .fill_off_o    (fill_off),
    .fill_byte_o   (fill_byte),
    .wr_en_o       (wr_en),
    .wr_id_o       (wr_id),
    .wr_val_o      (wr_val)
  );

  psync_cache u_cache (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (cache_clear),
    .fill_i      (fill),
    .fill_off_i  (fill_off),
    .fill_byte_i (fill_byte),
    .look_off_i  (look_off),
    .hit_o       (hit),
    .byte_o      (cached_byte)
  );

  psync_bits u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_id_i  (wr_id),
    .wr_val_i (wr_val),
    .rd_id_i  (rd_id_i),
    .rd_val_o (rd_pend_o)
  );

endmodule

// File: tb/pend_table_sync_bench.sv
module pend_table_sync_bench;
  import psync_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, table_zero_i = 1'b0;
  logic [63:0] pendbase_i = '0;
  logic        id_valid_i = 1'b0, id_last_i = 1'b0;
  logic [9:0]  id_i = '0, rd_id_i = '0;
  logic        id_ready_o, mem_req_o, busy_o, done_o, err_o, rd_pend_o;
  logic [47:0] mem_addr_o;
  logic        mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic [7:0]  mem_data_i = '0;

  always #4 clk = ~clk;

  pend_table_sync u_pend_table_sync (.*);

  int total = 0, bad = 0, fetch_cnt = 0;
  int lat = 0, seed = 0, err_off = -1, wait_cnt = 0;
  logic [47:0] cur_base = '0;
  logic [47:0] exp_q[$];
  bit  shadow [0:1023];
  bit  prev_vld = 0;
  int  prev_off = 0;
  bit  finished = 0;

  function automatic logic [7:0] mem_byte(input int off, input int s);
    return 8'((off * 37) + (s * 11) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        mem_err_i = 1'b0;
      end else if (mem_req_o) begin
        if (wait_cnt >= lat) begin
          int off;
          wait_cnt = 0;
          off = int'(mem_addr_o[6:0]);
          fetch_cnt++;
          if (exp_q.size() == 0) chk(0, "R3 unexpected read", longint'(mem_addr_o), 0);
          else begin
            logic [47:0] e;
            e = exp_q.pop_front();
            chk(mem_addr_o == e, "R1/R2 read address", longint'(mem_addr_o), longint'(e));
          end
          mem_data_i = mem_byte(off, seed);
          mem_err_i  = (off == err_off);
          mem_ack_i  = 1'b1;
        end else wait_cnt++;
      end
    end
  end

  task automatic start_scan(input logic [63:0] pb, input bit zero);
    pendbase_i   = pb;
    table_zero_i = zero;
    start_i      = 1'b1;
    cur_base     = {pb[47:16], 16'h0};
    prev_vld     = 0;
    @(negedge clk);
    start_i = 1'b0;
    table_zero_i = 1'b0;
  endtask

  // driver: pushes expected reads, offers one ID, updates shadow
  task automatic send_id(input int id, input bit last, input bit upd, output bit acc);
    int off;
    off = id >> 3;
    if (!prev_vld || off != prev_off) exp_q.push_back(cur_base + 48'(off));
    id_valid_i = 1'b1;
    id_i       = 10'(id);
    id_last_i  = last;
    acc = 0;
    for (int k = 0; k < 60; k++) begin
      if (id_ready_o) begin
        @(negedge clk);
        acc = 1;
        break;
      end
      @(negedge clk);
    end
    id_valid_i = 1'b0;
    id_last_i  = 1'b0;
    if (acc) begin
      prev_vld = 1;
      prev_off = off;
      if (upd) shadow[id] = mem_byte(off, seed)[id % 8];
    end
  endtask

  task automatic wait_done(input string req);
    bit seen;
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      if (done_o) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, req, 0, 1);
    chk(!busy_o, {req, " busy low at done"}, busy_o, 0);
    @(negedge clk);
    chk(!done_o, {req, " done single pulse"}, done_o, 0);
  endtask

  task automatic sweep(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < 1024; i++) begin
      rd_id_i = 10'(i);
      #1;
      if (rd_pend_o !== shadow[i]) begin
        if (mism == 0) $display("FAIL %s id=%0d actual=%0b expected=%0b", req, i, rd_pend_o, shadow[i]);
        mism++;
      end
    end
    total++;
    if (mism != 0) bad++;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    int fc;
    for (int i = 0; i < 1024; i++) shadow[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(!busy_o && !done_o && !err_o && !id_ready_o && !mem_req_o, "R10 idle outputs",
        {busy_o, done_o, err_o, id_ready_o, mem_req_o}, 0);
    sweep("R10 pending cleared");

    // scan A: contiguous IDs, last one hits (R1 R2 R3 R5 R8)
    lat = 2; seed = 1; fc = fetch_cnt;
    start_scan(64'hABCD_1234_5678_9ABC, 0);
    chk(busy_o, "R8 busy after start", busy_o, 1);
    send_id(3, 0, 1, acc);
    send_id(5, 0, 1, acc);
    send_id(7, 0, 1, acc);
    send_id(9, 0, 1, acc);
    send_id(17, 0, 1, acc);
    send_id(18, 0, 1, acc);
    send_id(100, 0, 1, acc);
    send_id(101, 1, 1, acc);
    chk(done_o, "R8 done right after last hit", done_o, 1);
    wait_done("R8 scan A end");
    chk(fetch_cnt - fc == 4, "R3 reads in scan A", fetch_cnt - fc, 4);
    chk(exp_q.size() == 0, "R3 pending expected reads A", exp_q.size(), 0);
    sweep("R5 pending after scan A");

    // scan B: new base, cold cache, revisit of a byte (R4 R2)
    lat = 0; seed = 2; fc = fetch_cnt;
    start_scan(64'h0000_00FF_EE00_FFFF, 0);
    send_id(100, 0, 1, acc);
    send_id(40, 0, 1, acc);
    send_id(41, 0, 1, acc);
    send_id(100, 1, 1, acc);
    wait_done("R8 scan B end");
    chk(fetch_cnt - fc == 3, "R4 reads in scan B", fetch_cnt - fc, 3);
    chk(exp_q.size() == 0, "R4 pending expected reads B", exp_q.size(), 0);
    sweep("R5 pending after scan B");

    // skipped scan (R7)
    fc = fetch_cnt;
    start_scan(64'hABCD_1234_5678_9ABC, 1);
    chk(done_o && !busy_o, "R7 done pulse on skip", {done_o, busy_o}, 2'b10);
    id_valid_i = 1'b1; id_i = 10'd3; id_last_i = 1'b1;
    acc = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (id_ready_o || mem_req_o || busy_o) acc = 1;
    end
    id_valid_i = 1'b0; id_last_i = 1'b0;
    chk(!acc, "R7 no activity after skip", acc, 0);
    chk(fetch_cnt == fc, "R7 no reads", fetch_cnt - fc, 0);
    sweep("R7 pending unchanged");

    // read error (R6)
    lat = 1; seed = 3; err_off = 37;
    start_scan(64'h0000_0000_0042_0000, 0);
    send_id(200, 0, 1, acc);
    send_id(201, 0, 1, acc);
    send_id(300, 0, 0, acc);
    begin
      bit e_seen, d_seen;
      e_seen = 0; d_seen = 0;
      for (int k = 0; k < 20; k++) begin
        if (done_o) d_seen = 1;
        if (err_o) begin
          e_seen = 1;
          chk(!busy_o && !id_ready_o, "R6 stopped at error", {busy_o, id_ready_o}, 0);
          break;
        end
        @(negedge clk);
      end
      chk(e_seen, "R6 error pulse", e_seen, 1);
      chk(!d_seen && !done_o, "R6 no done on error", done_o, 0);
    end
    @(negedge clk);
    chk(!err_o, "R6 error single pulse", err_o, 0);
    err_off = -1;
    prev_vld = 1; prev_off = 301 >> 3;
    send_id(301, 1, 0, acc);
    chk(!acc, "R6 no ID after error", acc, 0);
    sweep("R6 pending after error");

    // start during scan is ignored (R9)
    lat = 3; seed = 4; fc = fetch_cnt;
    start_scan(64'h0000_1111_0000_0000, 0);
    send_id(50, 0, 1, acc);
    start_i = 1'b1; table_zero_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; table_zero_i = 1'b0;
    chk(busy_o && !done_o, "R9 start ignored while busy", {busy_o, done_o}, 2'b10);
    send_id(51, 0, 1, acc);
    send_id(60, 1, 1, acc);
    wait_done("R9 scan E end");
    chk(fetch_cnt - fc == 2, "R3 reads in scan E", fetch_cnt - fc, 2);
    sweep("R5 pending after scan E");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule